// File: doc/BRIEF.md
# Bus-Writable Interrupt Request Register

This block holds seven interrupt request bits for a processor core: six ordinary hardware requests and one nonmaskable request. Software or an external agent changes the bits with a two-cycle write over a shared address/data bus. The address cycle chooses this register, and the data cycle that follows carries an enable field and a value field. In one transaction, every enabled bit takes its new value and every other bit keeps its old one. So a single write can raise some requests, drop others, and leave the rest unchanged. The register can be written over the bus but never read back.

Active-low interrupt pins and an active-low nonmaskable pin are sampled on every rising clock edge. A build parameter chooses how many ordinary pins are wired: one (bit 0 only) or all six. Each output request line is the registered OR of its register bit and its sampled pin. A bus write therefore cannot hide a request that a pin is still holding.

Top module: `irq_req_block`

## Requirements
- R1: A synchronous active-high reset clears the register bits, the sampled pin flops and all seven outputs. All outputs read 0 on the edge after reset.
- R2: An address cycle has `addr_valid`=1 and `wr_cmd`=1. It selects the register when bus bits [6:4] are all zero. All other bus bits are ignored during this cycle.
- R3: An address cycle with any of bus bits [6:4] set does not select the register. A following data cycle then leaves all outputs unchanged.
- R4: In the data cycle after a selecting address cycle, bus bit 16+i enables register bit i and bus bit i gives its new value, for i = 0..6. Bits whose enable is 0 keep their value.
- R5: A data cycle has no effect in three cases: it follows no address cycle, it follows an address cycle with `wr_cmd`=0, or it is a second data cycle after a selecting address cycle already used up by an earlier data cycle.
- R6: Ordinary pin `irq_pin_n[i]` low means request i is pending. Each `irq_req[i]` equals register bit i OR the inverted pin. A pin change shows on the output after the second rising edge. A register write shows after the first rising edge following its data cycle.
- R7: With `PIN_COUNT`=1, only `irq_pin_n[0]` is used. Pins 5..1 have no effect on the outputs.
- R8: `nmi_req` is register bit 6 OR the inverted, sampled `nmi_pin_n`. It has the same latency as R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ad | input | BUS_W | Multiplexed address/data bus |
| addr_valid | input | 1 | Address cycle strobe |
| wr_cmd | input | 1 | Address cycle is a write (1) or read (0) |
| data_valid | input | 1 | Data cycle strobe |
| irq_pin_n | input | 6 | Active-low hardware interrupt pins |
| nmi_pin_n | input | 1 | Active-low nonmaskable interrupt pin |
| irq_req | output | 6 | Hardware interrupt requests to the core |
| nmi_req | output | 1 | Nonmaskable interrupt request to the core |

## Verification
Two things can land in the same cycle: a bus data cycle that clears a bit, and a pin holding the same bit low. The bench pulls a pin low and then writes a clear to that bit. The output must stay high while the pin is held, and it must drop only after the pin is released. The same stimulus is also run with the register setting a bit while the pin is idle. In each case the bench compares the output with the OR of a bench-side register model and the inverted pin pattern.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int HW_BITS  = 6;
  localparam int REQ_BITS = HW_BITS + 1;
  localparam int NMI_IDX  = HW_BITS;
  localparam int SEL_LO   = 4;
  localparam int SEL_HI   = 6;
  localparam int VAL_LO   = 0;
  localparam int VAL_HI   = VAL_LO + REQ_BITS - 1;
  localparam int EN_LO    = 16;
  localparam int EN_HI    = EN_LO + REQ_BITS - 1;

  typedef logic [REQ_BITS-1:0] req_vec_t;

  function automatic req_vec_t apply_masked(req_vec_t cur, req_vec_t en, req_vec_t val);
    return (cur & ~en) | (val & en);
  endfunction
endpackage

// File: rtl/irq_bus_write.sv
`timescale 1ns/1ps
module irq_bus_write
  import irq_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus_ad,
  input  logic             addr_valid,
  input  logic             wr_cmd,
  input  logic             data_valid,
  output req_vec_t         reg_q
);
  logic     armed_q;
  logic     sel_hit;
  req_vec_t en_f;
  req_vec_t val_f;
  logic     unused_bus;

  assign sel_hit    = (bus_ad[SEL_HI:SEL_LO] == '0);
  assign en_f       = bus_ad[EN_HI:EN_LO];
  assign val_f      = bus_ad[VAL_HI:VAL_LO];
  assign unused_bus = ^{bus_ad[BUS_W-1:EN_HI+1], bus_ad[EN_LO-1:SEL_HI+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      reg_q   <= '0;
    end else begin
      if (data_valid && armed_q)
        reg_q <= apply_masked(reg_q, en_f, val_f);
      if (addr_valid)
        armed_q <= wr_cmd && sel_hit;
      else if (data_valid)
        armed_q <= 1'b0;
    end
  end

  // R4: disabled bits never move during an applied data cycle
  p_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (data_valid && armed_q) |=> (((reg_q ^ $past(reg_q)) & ~$past(en_f)) == '0));

  // R5: no data cycle on an armed write leaves the register alone
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !(data_valid && armed_q) |=> $stable(reg_q));

  // R3: a non-matching or read address cycle never arms
  p_no_arm_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && (!wr_cmd || bus_ad[SEL_HI:SEL_LO] != '0)) |=> !armed_q);
endmodule

// File: rtl/irq_pin_sync.sv
`timescale 1ns/1ps
module irq_pin_sync
  import irq_pkg::*;
#(
  parameter int PIN_COUNT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HW_BITS-1:0] irq_pin_n,
  input  logic               nmi_pin_n,
  output req_vec_t           samp_q
);
  for (genvar i = 0; i < HW_BITS; i++) begin : g_pin
    if (i < PIN_COUNT) begin : g_used
      always_ff @(posedge clk) begin
        if (rst) samp_q[i] <= 1'b0;
        else     samp_q[i] <= ~irq_pin_n[i];
      end
    end else begin : g_idle
      logic unused_pin;
      assign unused_pin = irq_pin_n[i];
      assign samp_q[i]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) samp_q[NMI_IDX] <= 1'b0;
    else     samp_q[NMI_IDX] <= ~nmi_pin_n;
  end

  // R6: pin 0 is always wired and is sampled inverted
  p_sample_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (samp_q[0] == ~$past(irq_pin_n[0])));

  // R8: nonmaskable pin sampled inverted
  p_nmi_sample_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (samp_q[NMI_IDX] == ~$past(nmi_pin_n)));
endmodule

// File: rtl/irq_req_block.sv
`timescale 1ns/1ps
module irq_req_block
  import irq_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int PIN_COUNT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_W-1:0]   bus_ad,
  input  logic               addr_valid,
  input  logic               wr_cmd,
  input  logic               data_valid,
  input  logic [HW_BITS-1:0] irq_pin_n,
  input  logic               nmi_pin_n,
  output logic [HW_BITS-1:0] irq_req,
  output logic               nmi_req
);
  req_vec_t reg_q;
  req_vec_t samp_q;
  req_vec_t out_q;

  irq_bus_write #(.BUS_W(BUS_W)) u_bus (
    .clk(clk), .rst(rst), .bus_ad(bus_ad), .addr_valid(addr_valid),
    .wr_cmd(wr_cmd), .data_valid(data_valid), .reg_q(reg_q)
  );

  irq_pin_sync #(.PIN_COUNT(PIN_COUNT)) u_pins (
    .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .nmi_pin_n(nmi_pin_n),
    .samp_q(samp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= reg_q | samp_q;
  end

  assign irq_req = out_q[HW_BITS-1:0];
  assign nmi_req = out_q[NMI_IDX];

  // R1: reset empties all outputs on the next edge
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && !nmi_req));

  // R6: outputs are the OR of the two sources one edge earlier
  p_merge_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_req == $past(reg_q[HW_BITS-1:0] | samp_q[HW_BITS-1:0])));

  // R8: nonmaskable output merges bit 6 of both sources
  p_nmi_merge_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (nmi_req == $past(reg_q[NMI_IDX] | samp_q[NMI_IDX])));
endmodule

// File: tb/test_irq_req_block.sv
`timescale 1ns/1ps
module test_irq_req_block;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_ad = '0;
  logic        addr_valid = 1'b0;
  logic        wr_cmd = 1'b0;
  logic        data_valid = 1'b0;
  logic [5:0]  irq_pin_n = 6'h3f;
  logic        nmi_pin_n = 1'b1;
  logic [5:0]  irq_req, irq_req1;
  logic        nmi_req, nmi_req1;

  int checks = 0;
  int errors = 0;
  logic [6:0] exp_reg = '0;

  always #4 clk = ~clk;

  irq_req_block i_irq_req_block (
    .clk(clk), .rst(rst), .bus_ad(bus_ad), .addr_valid(addr_valid), .wr_cmd(wr_cmd),
    .data_valid(data_valid), .irq_pin_n(irq_pin_n), .nmi_pin_n(nmi_pin_n),
    .irq_req(irq_req), .nmi_req(nmi_req)
  );

  irq_req_block #(.PIN_COUNT(1)) i_irq_req_block_one (
    .clk(clk), .rst(rst), .bus_ad(bus_ad), .addr_valid(addr_valid), .wr_cmd(wr_cmd),
    .data_valid(data_valid), .irq_pin_n(irq_pin_n), .nmi_pin_n(nmi_pin_n),
    .irq_req(irq_req1), .nmi_req(nmi_req1)
  );

  function automatic logic [6:0] exp_full();
    return exp_reg | {~nmi_pin_n, ~irq_pin_n};
  endfunction

  function automatic logic [6:0] exp_one();
    return exp_reg | {~nmi_pin_n, 5'b0, ~irq_pin_n[0]};
  endfunction

  task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_both(input string tag);
    chk({tag, " six-pin"}, {nmi_req, irq_req}, exp_full());
    chk({tag, " one-pin R7"}, {nmi_req1, irq_req1}, exp_one());
  endtask

  // address cycle, data cycle, then wait until the output register has moved
  task automatic txn(input logic [2:0] sel, input logic [31:0] filler, input logic is_wr,
                     input logic [6:0] en, input logic [6:0] val);
    @(negedge clk);
    addr_valid = 1'b1; wr_cmd = is_wr;
    bus_ad = (filler & ~32'h70) | (32'(sel) << 4);
    @(negedge clk);
    addr_valid = 1'b0; wr_cmd = 1'b0; data_valid = 1'b1;
    bus_ad = (filler & 32'hff80_ff80) | (32'(en) << 16) | 32'(val);
    @(negedge clk);
    data_valid = 1'b0;
    @(negedge clk);
    if (is_wr && sel == 3'd0) exp_reg = (exp_reg & ~en) | (val & en);
  endtask

  task automatic lone_data(input logic [6:0] en, input logic [6:0] val);
    @(negedge clk);
    data_valid = 1'b1; bus_ad = (32'(en) << 16) | 32'(val);
    @(negedge clk);
    data_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_pins(input logic [5:0] p, input logic n);
    @(negedge clk);
    irq_pin_n = p; nmi_pin_n = n;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_both("R1 reset state");

    // R2/R3: sweep the select field with varied filler bits
    for (int s = 0; s < 8; s++) begin
      txn(3'(s), 32'hA5C3_0000 ^ (32'(s) * 32'h0101_0080), 1'b1, 7'h7f, 7'(s * 17 + 1));
      chk_both(s == 0 ? "R2 select hit" : "R3 select miss");
      txn(3'd0, 32'h0, 1'b1, 7'h7f, 7'h00);
      chk_both("R2 clear after select");
    end

    // R4: near-exhaustive enable sweep with several value patterns
    for (int e = 0; e < 128; e++) begin
      for (int v = 0; v < 4; v++) begin
        txn(3'd0, 32'(e) * 32'h0123_4567, 1'b1, 7'(e), 7'(e * 5 + v * 41 + 3));
        chk_both("R4 masked update");
      end
    end

    // R5: orphan, read-armed and repeated data cycles
    txn(3'd0, 32'h0, 1'b1, 7'h7f, 7'h2a);
    chk_both("R4 preset");
    lone_data(7'h7f, 7'h55);
    chk_both("R5 orphan data");
    txn(3'd0, 32'h0, 1'b0, 7'h7f, 7'h55);
    chk_both("R5 read address cycle");
    txn(3'd0, 32'h0, 1'b1, 7'h01, 7'h01);
    lone_data(7'h7f, 7'h00);
    chk_both("R5 second data cycle");

    // R6/R7/R8: pin sweep over all pin and nmi patterns
    txn(3'd0, 32'h0, 1'b1, 7'h7f, 7'h00);
    for (int p = 0; p < 128; p++) begin
      set_pins(6'(p), p[6]);
      chk_both("R6 R8 pin sweep");
    end
    set_pins(6'h3f, 1'b1);

    // R6: pin and register merged, with bus clear on a held pin
    set_pins(6'h3b, 1'b0);
    txn(3'd0, 32'h0, 1'b1, 7'h44, 7'h00);
    chk_both("R6 clear while pin held");
    txn(3'd0, 32'h0, 1'b1, 7'h02, 7'h02);
    chk_both("R6 set with other pin held");
    set_pins(6'h3f, 1'b1);
    chk_both("R6 R8 pin released");

    // R6: latency of a pin change is two edges, not one
    @(negedge clk);
    irq_pin_n = 6'h3e;
    @(negedge clk);
    chk("R6 pin latency one edge", {nmi_req, irq_req}, exp_reg);
    @(negedge clk);
    chk("R6 pin latency two edges", {nmi_req, irq_req}, exp_full());
    set_pins(6'h3f, 1'b1);

    // R1: reset after activity
    @(negedge clk);
    rst = 1'b1; irq_pin_n = 6'h00; nmi_pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset clears", {nmi_req, irq_req}, 7'h00);
    chk("R1 reset clears one-pin", {nmi_req1, irq_req1}, 7'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule